// File: doc/BRIEF.md
# Delayed Register-Write Queue

This block holds register updates that must take effect some number of timing ticks after they are issued. An issuing stage pushes an entry that names a destination register, a countdown, a value, an operand size (narrow half-word or full word) and, optionally, a bit position. Each accepted tick counts down every waiting entry. An entry whose count reaches zero presents its update on a single register-file write port. The update is either a whole-operand write or a single-bit set or clear.

Entries may expire in any order, because each one has its own countdown. Storage is reclaimed strictly from the oldest entry, so a young entry that has already written keeps its slot until every older entry has written too. When several entries expire on the same tick, their writes leave one per cycle, oldest first. During that time the block raises a busy flag and does not accept further ticks.

The write port carries a bit mask and data. The register file applies `new = (old & ~mask) | (data & mask)`, so a bit clear leaves every other bit of the destination unchanged.

Top module: `delayed_write_queue`

## Requirements
- R1: After reset the queue is empty: `enq_full_o`, `busy_o`, `wr_en_o` and `err_o` are all 0.
- R2: A push (`enq_valid_i` high) is stored when `enq_full_o` is 0 at that clock edge. `enq_full_o` is 1 exactly when all NSLOT slots are occupied. A push made while full is discarded and never produces a write.
- R3: A tick is accepted on a clock edge where `tick_i` is 1 and `busy_o` is 0. An entry pushed with countdown D ≥ 1 expires on its D-th accepted tick, and a pushed countdown of 0 is taken as 1. If no older entry is waiting to write, `wr_en_o` is 1 in the cycle after that edge, with the entry's destination on `wr_dest_o`.
- R4: When `tick_i` is 1 in a cycle where `busy_o` is 1, the tick is not accepted and no countdown changes.
- R5: A bit entry (`enq_bit_en_i`=1) writes `wr_mask_o` = 1 << b. The bit index b is `enq_bit_i` when `enq_wide_i`=1, and its low log2(DATA_W)-1 bits when `enq_wide_i`=0. `wr_data_o` equals the mask when the value is nonzero within the operand size (low DATA_W/2 bits if narrow, all bits if wide), and 0 otherwise.
- R6: A word entry (`enq_bit_en_i`=0) with `enq_wide_i`=1 writes a mask of all ones and the full value as data. With `enq_wide_i`=0 it writes a mask of ones in the low DATA_W/2 bits and the low half of the value, zero-extended, as data.
- R7: Writes of entries that expire on the same tick leave one per cycle, in push order from the oldest. `busy_o` is 1 in exactly the cycles where `wr_en_o` is 1.
- R8: A slot is freed only after its own write has left and all older slots have been freed. Slots are freed at most one per cycle, starting the cycle after the oldest slot's write.
- R9: A push accepted on the same edge as an accepted tick does not count that tick. A push presented while full is rejected even on an edge where the oldest slot is freed.
- R10: `err_o`, which flags a nonzero pointer difference with zero occupancy, stays 0 in operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Push request |
| enq_dest_i | input | IDX_W | Destination register index |
| enq_delay_i | input | DLY_W | Tick countdown (0 taken as 1) |
| enq_value_i | input | DATA_W | Value to write, or bit sense when nonzero |
| enq_wide_i | input | 1 | 1 = full DATA_W operand, 0 = low half |
| enq_bit_en_i | input | 1 | 1 = single-bit set/clear, 0 = operand write |
| enq_bit_i | input | log2(DATA_W) | Bit position for a bit entry |
| enq_full_o | output | 1 | All slots occupied; pushes are discarded |
| tick_i | input | 1 | Countdown tick request |
| busy_o | output | 1 | Writes are draining; ticks are not accepted |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_dest_o | output | IDX_W | Register index of the write |
| wr_mask_o | output | DATA_W | Bits of the destination to be replaced |
| wr_data_o | output | DATA_W | New bit values under the mask |
| err_o | output | 1 | Pointer/occupancy inconsistency |

## Verification
Two actions can land on the same edge: a push and an accepted tick, and a push and the freeing of the oldest slot. Directed sequences push an entry with countdown 1 on the tick edge, and push into a full queue while a tick is taken. Random traffic then overlaps pushes, ticks and head frees freely. Each cycle, the write port, busy and full are compared with a cycle model built from the requirements. That model decides whether the new entry skipped the tick, whether the rejected push stayed out of the queue and whether freeing stays in push order.

// File: rtl/dwq_pkg.sv
package dwq_pkg;

   // Life cycle of one queue slot
   typedef enum logic [1:0] {
      SL_EMPTY = 2'd0,   // free
      SL_WAIT  = 2'd1,   // counting down
      SL_PEND  = 2'd2,   // expired, write not yet issued
      SL_DONE  = 2'd3    // write issued, waiting to be reclaimed at the head
   } slot_st_e;

endpackage

// File: rtl/dwq_slot.sv
module dwq_slot
   import dwq_pkg::*;
#(
   parameter int DLY_W = 4,
   parameter int PL_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_dly_i,
   input  logic [PL_W-1:0]  load_pl_i,
   input  logic             tick_i,
   input  logic             issue_i,
   input  logic             free_i,
   output slot_st_e         st_o,
   output logic [PL_W-1:0]  pl_o
);

   slot_st_e         st_q;
   logic [DLY_W-1:0] cnt_q;
   logic [PL_W-1:0]  pl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SL_EMPTY;
         cnt_q <= '0;
         pl_q  <= '0;
      end else begin
         if (free_i) begin
            st_q <= SL_EMPTY;
         end else if (load_i) begin
            st_q  <= SL_WAIT;
            cnt_q <= (load_dly_i == '0) ? DLY_W'(1) : load_dly_i;
            pl_q  <= load_pl_i;
         end else if (st_q == SL_WAIT && tick_i) begin
            cnt_q <= cnt_q - DLY_W'(1);
            if (cnt_q == DLY_W'(1)) st_q <= SL_PEND;
         end else if (st_q == SL_PEND && issue_i) begin
            st_q <= SL_DONE;
         end
      end
   end

   assign st_o = st_q;
   assign pl_o = pl_q;

   AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (st_q == SL_PEND && $past(st_q) == SL_WAIT) |-> ($past(tick_i) && $past(cnt_q) == DLY_W'(1))); // R3
   AST_FREE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == SL_EMPTY && $past(st_q) != SL_EMPTY) |-> ($past(st_q) == SL_DONE)); // R8
   AST_LOAD_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) load_i |-> (st_q == SL_EMPTY)); // R2

endmodule

// File: rtl/dwq_pick.sv
module dwq_pick #(
   parameter int N     = 8,
   parameter int PTR_W = 3
) (
   input  logic [N-1:0]     pend_i,
   input  logic [PTR_W-1:0] base_i,
   output logic [PTR_W-1:0] sel_o,
   output logic             vld_o
);

   // Oldest pending slot, scanning forward from the head pointer.
   // Walking from the far end lets the nearest hit win last.
   always_comb begin
      sel_o = '0;
      vld_o = 1'b0;
      for (int k = N - 1; k >= 0; k--) begin
         if (pend_i[base_i + PTR_W'(k)]) begin
            sel_o = base_i + PTR_W'(k);
            vld_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dwq_wrfmt.sv
module dwq_wrfmt #(
   parameter int DATA_W = 64,
   parameter int BIT_W  = 6
) (
   input  logic [DATA_W-1:0] value_i,
   input  logic              wide_i,
   input  logic              bit_en_i,
   input  logic [BIT_W-1:0]  bitno_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] size_mask;
   logic [DATA_W-1:0] onehot;
   logic [BIT_W-1:0]  bit_eff;
   logic              nonzero;

   always_comb begin
      size_mask = wide_i ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
      bit_eff   = wide_i ? bitno_i : {1'b0, bitno_i[BIT_W-2:0]};
      onehot    = DATA_W'(1) << bit_eff;
      nonzero   = |(value_i & size_mask);
      if (bit_en_i) begin
         // set or clear one bit; the mask protects every other bit
         mask_o = onehot;
         data_o = nonzero ? onehot : '0;
      end else begin
         mask_o = size_mask;
         data_o = value_i & size_mask;
      end
   end

endmodule

// File: rtl/delayed_write_queue.sv
module delayed_write_queue
   import dwq_pkg::*;
#(
   parameter int NSLOT  = 8,
   parameter int DLY_W  = 4,
   parameter int IDX_W  = 5,
   parameter int DATA_W = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enq_valid_i,
   input  logic [IDX_W-1:0]            enq_dest_i,
   input  logic [DLY_W-1:0]            enq_delay_i,
   input  logic [DATA_W-1:0]           enq_value_i,
   input  logic                        enq_wide_i,
   input  logic                        enq_bit_en_i,
   input  logic [$clog2(DATA_W)-1:0]   enq_bit_i,
   output logic                        enq_full_o,
   input  logic                        tick_i,
   output logic                        busy_o,
   output logic                        wr_en_o,
   output logic [IDX_W-1:0]            wr_dest_o,
   output logic [DATA_W-1:0]           wr_mask_o,
   output logic [DATA_W-1:0]           wr_data_o,
   output logic                        err_o
);

   localparam int PTR_W  = $clog2(NSLOT);
   localparam int CNT_W  = $clog2(NSLOT + 1);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int PL_W   = IDX_W + DATA_W + 2 + BIT_W;
   localparam int OFS_BE = BIT_W;
   localparam int OFS_WD = BIT_W + 1;
   localparam int OFS_VL = BIT_W + 2;
   localparam int OFS_DS = BIT_W + 2 + DATA_W;

   // elaboration-time parameter checks
   if (NSLOT < 2 || (1 << PTR_W) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (1 << BIT_W) != DATA_W) begin : g_bad_data_w
      $error("DATA_W must be a power of two, at least 8");
   end
   if (DLY_W < 1 || IDX_W < 1) begin : g_bad_widths
      $error("DLY_W and IDX_W must be at least 1");
   end

   logic [PTR_W-1:0] rptr_q, wptr_q;
   logic [CNT_W-1:0] cnt_q;
   slot_st_e         st_v [NSLOT];
   logic [PL_W-1:0]  pl_v [NSLOT];
   logic [NSLOT-1:0] pend_v;
   logic [PTR_W-1:0] sel;
   logic             sel_vld;
   logic             take, tick_go, head_free, full, busy;
   logic [PL_W-1:0]  enq_pl, sel_pl;

   assign full      = (cnt_q == CNT_W'(NSLOT));
   assign take      = enq_valid_i && !full;
   assign busy      = |pend_v;
   assign tick_go   = tick_i && !busy;
   assign head_free = (st_v[rptr_q] == SL_DONE);
   assign enq_pl    = {enq_dest_i, enq_value_i, enq_wide_i, enq_bit_en_i, enq_bit_i};

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      dwq_slot #(
         .DLY_W (DLY_W),
         .PL_W  (PL_W)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (take && wptr_q == PTR_W'(g)),
         .load_dly_i (enq_delay_i),
         .load_pl_i  (enq_pl),
         .tick_i     (tick_go),
         .issue_i    (sel_vld && sel == PTR_W'(g)),
         .free_i     (head_free && rptr_q == PTR_W'(g)),
         .st_o       (st_v[g]),
         .pl_o       (pl_v[g])
      );
      assign pend_v[g] = (st_v[g] == SL_PEND);
   end

   dwq_pick #(
      .N     (NSLOT),
      .PTR_W (PTR_W)
   ) u_pick (
      .pend_i (pend_v),
      .base_i (rptr_q),
      .sel_o  (sel),
      .vld_o  (sel_vld)
   );

   assign sel_pl = pl_v[sel];

   dwq_wrfmt #(
      .DATA_W (DATA_W),
      .BIT_W  (BIT_W)
   ) u_fmt (
      .value_i  (sel_pl[OFS_VL +: DATA_W]),
      .wide_i   (sel_pl[OFS_WD]),
      .bit_en_i (sel_pl[OFS_BE]),
      .bitno_i  (sel_pl[BIT_W-1:0]),
      .mask_o   (wr_mask_o),
      .data_o   (wr_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q <= '0;
         wptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (take)      wptr_q <= wptr_q + PTR_W'(1);
         if (head_free) rptr_q <= rptr_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(take) - CNT_W'(head_free);
      end
   end

   assign enq_full_o = full;
   assign busy_o     = busy;
   assign wr_en_o    = sel_vld;
   assign wr_dest_o  = sel_pl[OFS_DS +: IDX_W];
   assign err_o      = (rptr_q != wptr_q) && (cnt_q == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_W'(NSLOT)); // R2
   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (enq_valid_i && enq_full_o) |=> $stable(wptr_q)); // R2
   AST_PTR_CONSIST: assert property (@(posedge clk) disable iff (!rst_n) !err_o); // R10
   AST_ONE_WRITE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> ($countones(pend_v) == $past($countones(pend_v)) - 1)); // R7

endmodule

// File: tb/tb_delayed_write_queue.sv
module tb_delayed_write_queue;

   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid_i = 1'b0;
   logic [4:0]  enq_dest_i = '0;
   logic [3:0]  enq_delay_i = '0;
   logic [63:0] enq_value_i = '0;
   logic        enq_wide_i = 1'b0;
   logic        enq_bit_en_i = 1'b0;
   logic [5:0]  enq_bit_i = '0;
   logic        tick_i = 1'b0;
   logic        enq_full_o, busy_o, wr_en_o, err_o;
   logic [4:0]  wr_dest_o;
   logic [63:0] wr_mask_o, wr_data_o;

   always #4 clk = ~clk;   // 125 MHz

   delayed_write_queue dut (
      .clk(clk), .rst_n(rst_n),
      .enq_valid_i(enq_valid_i), .enq_dest_i(enq_dest_i), .enq_delay_i(enq_delay_i),
      .enq_value_i(enq_value_i), .enq_wide_i(enq_wide_i), .enq_bit_en_i(enq_bit_en_i),
      .enq_bit_i(enq_bit_i), .enq_full_o(enq_full_o), .tick_i(tick_i), .busy_o(busy_o),
      .wr_en_o(wr_en_o), .wr_dest_o(wr_dest_o), .wr_mask_o(wr_mask_o),
      .wr_data_o(wr_data_o), .err_o(err_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit fin = 1'b0;

   // stimulus for the next cycle
   bit          d_ev, d_tk, d_wide, d_be;
   int          d_dly;
   logic [4:0]  d_dest;
   logic [63:0] d_val;
   logic [5:0]  d_bit;

   // cycle model: 0 empty, 1 waiting, 2 expired, 3 written
   int          m_st [NS];
   int          m_cnt [NS];
   logic [4:0]  m_dest [NS];
   logic [63:0] m_val [NS];
   bit          m_wide [NS], m_be [NS];
   logic [5:0]  m_bit [NS];
   int          m_r = 0, m_w = 0, m_n = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // expected mask (R5, R6)
   function automatic logic [63:0] f_mask(bit wide, bit be, logic [5:0] b);
      if (be) return 64'd1 << (wide ? b : {1'b0, b[4:0]});
      return wide ? '1 : 64'h0000_0000_FFFF_FFFF;
   endfunction

   function automatic logic [63:0] f_data(logic [63:0] v, bit wide, bit be, logic [5:0] b);
      logic [63:0] sz = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
      if (be) return ((v & sz) != 0) ? f_mask(wide, be, b) : 64'd0;
      return v & sz;
   endfunction

   function automatic int m_oldest();
      for (int k = 0; k < NS; k++)
         if (m_st[(m_r + k) % NS] == 2) return (m_r + k) % NS;
      return -1;
   endfunction

   function automatic int m_npend();
      int c = 0;
      for (int i = 0; i < NS; i++) if (m_st[i] == 2) c++;
      return c;
   endfunction

   task automatic compare();
      int s = m_oldest();
      chk("R7", {63'd0, busy_o}, {63'd0, (s >= 0)});
      chk("R3", {63'd0, wr_en_o}, {63'd0, (s >= 0)});
      chk("R2", {63'd0, enq_full_o}, {63'd0, (m_n == NS)});
      chk("R10", {63'd0, err_o}, 64'd0);
      if (s >= 0 && wr_en_o) begin
         chk((m_npend() > 1) ? "R7" : "R3", {59'd0, wr_dest_o}, {59'd0, m_dest[s]});
         chk(m_be[s] ? "R5" : "R6", wr_mask_o, f_mask(m_wide[s], m_be[s], m_bit[s]));
         chk(m_be[s] ? "R5" : "R6", wr_data_o, f_data(m_val[s], m_wide[s], m_be[s], m_bit[s]));
      end
   endtask

   task automatic model_update();
      bit full0 = (m_n == NS);
      int sel = m_oldest();
      bit take = d_ev && !full0;
      bit tgo = d_tk && (sel < 0);
      bit hfree = (m_st[m_r] == 3);
      for (int i = 0; i < NS; i++) begin
         if (hfree && i == m_r) m_st[i] = 0;
         else if (take && i == m_w) begin
            m_st[i] = 1; m_cnt[i] = (d_dly == 0) ? 1 : d_dly;
            m_dest[i] = d_dest; m_val[i] = d_val; m_wide[i] = d_wide;
            m_be[i] = d_be; m_bit[i] = d_bit;
         end else if (m_st[i] == 1 && tgo) begin
            if (m_cnt[i] == 1) m_st[i] = 2;
            m_cnt[i]--;
         end else if (m_st[i] == 2 && i == sel) m_st[i] = 3;
      end
      if (take) m_w = (m_w + 1) % NS;
      if (hfree) m_r = (m_r + 1) % NS;
      m_n = m_n + int'(take) - int'(hfree);
   endtask

   task automatic step(input bit ev, input int dly, input bit tk);
      @(negedge clk);
      compare();
      d_ev = ev; d_dly = dly; d_tk = tk;
      enq_valid_i = ev; enq_delay_i = 4'(dly); tick_i = tk;
      enq_dest_i = d_dest; enq_value_i = d_val; enq_wide_i = d_wide;
      enq_bit_en_i = d_be; enq_bit_i = d_bit;
      @(posedge clk);
      model_update();
   endtask

   task automatic pay(input logic [4:0] ds, input logic [63:0] v, input bit w, input bit be, input logic [5:0] b);
      d_dest = ds; d_val = v; d_wide = w; d_be = be; d_bit = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < NS; i++) m_st[i] = 0;
      pay(5'd0, 64'd0, 1'b0, 1'b0, 6'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", {63'd0, wr_en_o}, 64'd0);
      chk("R1", {63'd0, enq_full_o}, 64'd0);
      chk("R1", {63'd0, busy_o}, 64'd0);
      chk("R1", {63'd0, err_o}, 64'd0);

      // R3: countdown 0 is taken as 1
      pay(5'd3, 64'h1234_5678_9abc_def0, 1'b1, 1'b0, 6'd0);
      step(1'b1, 0, 1'b0);
      step(1'b0, 0, 1'b1);
      #2 chk("R3", {63'd0, wr_en_o}, 64'd1);
      chk("R6", wr_data_o, 64'h1234_5678_9abc_def0);
      idle(3);

      // R9: push on the tick edge skips that tick
      pay(5'd9, 64'hFFFF_0000_0000_0001, 1'b0, 1'b0, 6'd0);
      step(1'b1, 1, 1'b1);
      #2 chk("R9", {63'd0, wr_en_o}, 64'd0);
      step(1'b0, 0, 1'b1);
      #2 chk("R9", {63'd0, wr_en_o}, 64'd1);
      chk("R6", wr_mask_o, 64'h0000_0000_FFFF_FFFF);
      idle(3);

      // R5: narrow bit clear, index folded into low half
      pay(5'd7, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 6'd37);
      step(1'b1, 1, 1'b0);
      step(1'b0, 0, 1'b1);
      #2 chk("R5", wr_mask_o, 64'h20);
      chk("R5", wr_data_o, 64'd0);
      idle(3);

      // R4: ticks while busy are not counted
      pay(5'd1, 64'd1, 1'b1, 1'b1, 6'd63); step(1'b1, 1, 1'b0);
      pay(5'd2, 64'd5, 1'b1, 1'b0, 6'd0);  step(1'b1, 1, 1'b0);
      pay(5'd4, 64'd0, 1'b1, 1'b1, 6'd2);  step(1'b1, 2, 1'b0);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b0);
      #2 chk("R4", {63'd0, wr_en_o}, 64'd0);
      step(1'b0, 0, 1'b1);
      #2 chk("R4", {63'd0, wr_en_o}, 64'd1);
      chk("R4", {59'd0, wr_dest_o}, 64'd4);
      idle(12);

      // R7/R8/R9: fill, reject while full, out-of-order expiry
      for (int i = 0; i < NS; i++) begin
         pay(5'(i + 16), {$urandom, $urandom}, 1'($urandom), 1'($urandom), 6'($urandom));
         step(1'b1, (i == 0) ? 4 : 1, 1'b0);
      end
      #2 chk("R2", {63'd0, enq_full_o}, 64'd1);
      pay(5'd31, 64'hDEAD, 1'b1, 1'b0, 6'd0);
      step(1'b1, 1, 1'b1);
      #2 chk("R9", {63'd0, busy_o}, 64'd1);
      chk("R2", {63'd0, enq_full_o}, 64'd1);
      idle(7);
      #2 chk("R7", {63'd0, busy_o}, 64'd0);
      chk("R8", {63'd0, enq_full_o}, 64'd1);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      #2 chk("R8", {63'd0, wr_en_o}, 64'd1);
      chk("R8", {59'd0, wr_dest_o}, 64'd16);
      idle(10);
      #2 chk("R8", {63'd0, enq_full_o}, 64'd0);

      // constrained random traffic, fixed seed
      void'($urandom(32'h5EED_1234));
      for (int c = 0; c < 4000; c++) begin
         logic [63:0] v = {$urandom, $urandom};
         if ($urandom % 4 == 0) v = 64'd0;
         else if ($urandom % 4 == 0) v = {v[63:32], 32'd0};
         pay(5'($urandom), v, 1'($urandom), 1'($urandom), 6'($urandom));
         step(($urandom % 10) < 4, int'($urandom % 6), ($urandom % 10) < 4);
      end
      idle(40);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      fin = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule